// File: doc/BRIEF.md
# Shared opcode/data bus link with lowest-bit opcode normalisation

This block carries two kinds of traffic over one 8-bit bus. A sideband mode line tells the far end which kind is present. The sending half has two jobs. It can turn a small operation selector (nine legal values) into a code with at most one bit set. It can also forward an arbitrary byte unchanged. Either way, it drives the mode line alongside the bus.

The receiving half treats the bus according to the mode line:

- **Opcode traffic:** it keeps only the lowest-numbered set bit. Its output therefore never has more than one bit high, even when the bus is corrupted.
- **Data traffic:** it passes the byte straight through.

A debug flag goes high when opcode traffic shows more than one set bit. A parameter chooses where the decoded byte comes out: from a clocked register with a synchronous clear, or directly from the combinational path.

The two halves appear as separate port groups on one top. A system can join them with wires, or drive the receiver from another source.

Top module: `obm_link`

## Requirements
- R1: With txMode=0, a selector value of 0 drives busData=0x00, and a selector value k in 1..8 drives busData with only bit k-1 set.
- R2: With txMode=0, any selector value from 9 to 15 drives busData=0x00.
- R3: With txMode=1, busData equals txData bit for bit. busMode always equals txMode.
- R4: With rxMode=0, the decoded byte has exactly one bit set, at the position of the lowest-numbered set bit of rxBus. Bit 0 wins over every other bit, and bit 7 loses to every other bit.
- R5: With rxMode=0 and rxBus=0x00, the decoded byte is 0x00.
- R6: With rxMode=1, the decoded byte equals rxBus bit for bit, whatever the number of set bits.
- R7: rxMultiHot is combinational. It is 1 exactly when rxMode=0 and rxBus has two or more bits set; otherwise it is 0.
- R8: With REG_OUT=1 (default), rxData takes the decoded byte at the rising clk edge after the inputs settle and holds it between edges. While rst=1 at a rising edge, rxData becomes 0x00.
- R9: Feeding busData/busMode into rxBus/rxMode returns, one clock later, the sent code for every selector value 0..8 and every data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high clear of rxData |
| txMode | input | 1 | Sender mode: 0 opcode, 1 raw data |
| txSel | input | 4 | Operation selector, legal 0..8 |
| txData | input | 8 | Raw byte to forward when txMode=1 |
| busData | output | 8 | Encoded bus toward the receiver |
| busMode | output | 1 | Mode line travelling with busData |
| rxMode | input | 1 | Receiver mode: 0 opcode, 1 raw data |
| rxBus | input | 8 | Bus value seen by the receiver |
| rxData | output | 8 | Decoded byte (registered when REG_OUT=1) |
| rxMultiHot | output | 1 | Debug flag: opcode traffic with two or more bits set |

## Verification
The assertions check several properties on every cycle:

- opcode traffic never leaves the sender with more than one bit set;
- the registered output is at most one-hot after an opcode cycle;
- a data cycle is reproduced exactly one edge later;
- reset clears the output;
- the debug flag is never raised during data traffic.

Some behaviour is shown only by the bench's scenarios:

- which bit survives normalisation when several are set, including the bit 0 and bit 7 extremes;
- the exact mapping from selector to code, and what illegal selectors produce;
- full round trips from sender to receiver.

// File: rtl/obm_pkg.sv
package obm_pkg;
  typedef struct packed {
    logic takeOpcode;
    logic takeRaw;
    logic multiHot;
  } rxStrobes_t;
endpackage

// File: rtl/obm_tx.sv
module obm_tx #(
  parameter int BUS_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [BUS_W-1:0] data,
  output logic [BUS_W-1:0] busOut,
  output logic             busModeOut
);
  logic [BUS_W-1:0] opCode;

  always_comb begin
    opCode = '0;
    for (int k = 1; k <= BUS_W; k++) begin
      if (sel == SEL_W'(k)) opCode[k-1] = 1'b1;
    end
  end

  assign busOut     = mode ? data : opCode;
  assign busModeOut = mode;

  // R1: opcode traffic leaving the sender has at most one bit set
  always_comb begin
    if (mode == 1'b0 && !$isunknown(sel)) begin
      assert_tx_onehot0_R1: assert ($onehot0(busOut));
    end
  end
endmodule

// File: rtl/obm_rx_ctrl.sv
module obm_rx_ctrl
  import obm_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             mode,
  input  logic [BUS_W-1:0] bus,
  output rxStrobes_t       strobes
);
  logic severalSet;

  assign severalSet = (bus & (bus - BUS_W'(1))) != '0;

  always_comb begin
    strobes.takeOpcode = ~mode;
    strobes.takeRaw    = mode;
    strobes.multiHot   = ~mode & severalSet;
  end

  // R7: the debug flag never rises during data traffic
  always_comb begin
    if (!$isunknown(mode) && strobes.multiHot) begin
      assert_flag_opcode_only_R7: assert (mode == 1'b0);
    end
  end
endmodule

// File: rtl/obm_rx_datapath.sv
module obm_rx_datapath
  import obm_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus,
  input  rxStrobes_t       strobes,
  output logic [BUS_W-1:0] dataOut
);
  logic [BUS_W-1:0] lowestOnly;
  logic [BUS_W-1:0] nextOut;

  assign lowestOnly = bus & (~bus + BUS_W'(1));

  always_comb begin
    if (strobes.takeRaw)         nextOut = bus;
    else if (strobes.takeOpcode) nextOut = lowestOnly;
    else                         nextOut = '0;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [BUS_W-1:0] outQ;

      always_ff @(posedge clk) begin
        if (rst) outQ <= '0;
        else     outQ <= nextOut;
      end

      assign dataOut = outQ;

      // R4: after an opcode cycle the output holds at most one set bit
      assert_opcode_onehot0_R4: assert property (@(posedge clk) disable iff (rst)
        strobes.takeOpcode |=> $onehot0(dataOut));

      // R6: a data cycle comes out unchanged one edge later
      assert_raw_passthru_R6: assert property (@(posedge clk) disable iff (rst)
        strobes.takeRaw |=> (dataOut == $past(bus)));

      // R8: reset clears the registered output
      assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (dataOut == '0));
    end else begin : g_comb
      assign dataOut = nextOut;
    end
  endgenerate
endmodule

// File: rtl/obm_link.sv
module obm_link
  import obm_pkg::*;
#(
  parameter  int BUS_W   = 8,
  parameter  bit REG_OUT = 1'b1,
  localparam int SEL_W   = $clog2(BUS_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             txMode,
  input  logic [SEL_W-1:0] txSel,
  input  logic [BUS_W-1:0] txData,
  output logic [BUS_W-1:0] busData,
  output logic             busMode,
  input  logic             rxMode,
  input  logic [BUS_W-1:0] rxBus,
  output logic [BUS_W-1:0] rxData,
  output logic             rxMultiHot
);
  rxStrobes_t strobes;

  obm_tx #(.BUS_W(BUS_W), .SEL_W(SEL_W)) u_tx (
    .mode(txMode), .sel(txSel), .data(txData),
    .busOut(busData), .busModeOut(busMode)
  );

  obm_rx_ctrl #(.BUS_W(BUS_W)) u_ctrl (
    .mode(rxMode), .bus(rxBus), .strobes(strobes)
  );

  obm_rx_datapath #(.BUS_W(BUS_W), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rst(rst), .bus(rxBus), .strobes(strobes), .dataOut(rxData)
  );

  assign rxMultiHot = strobes.multiHot;
endmodule

// File: tb/sim_obm_link.sv
module sim_obm_link;
  logic       clk = 1'b0;
  logic       rst;
  logic       txMode;
  logic [3:0] txSel;
  logic [7:0] txData;
  logic [7:0] busData;
  logic       busMode;
  logic       useLoop;
  logic       drvMode;
  logic [7:0] drvBus;
  logic       rxMode;
  logic [7:0] rxBus;
  logic [7:0] rxData;
  logic       rxMultiHot;

  int applied = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  assign rxBus  = useLoop ? busData : drvBus;
  assign rxMode = useLoop ? busMode : drvMode;

  obm_link u0 (
    .clk(clk), .rst(rst), .txMode(txMode), .txSel(txSel), .txData(txData),
    .busData(busData), .busMode(busMode), .rxMode(rxMode), .rxBus(rxBus),
    .rxData(rxData), .rxMultiHot(rxMultiHot)
  );

  // {mode, bus, expected decoded byte, expected flag}
  localparam logic [17:0] VEC [12] = '{
    {1'b0, 8'h01, 8'h01, 1'b0},
    {1'b0, 8'h06, 8'h02, 1'b1},
    {1'b0, 8'h80, 8'h80, 1'b0},
    {1'b0, 8'h00, 8'h00, 1'b0},
    {1'b0, 8'hFF, 8'h01, 1'b1},
    {1'b0, 8'hA0, 8'h20, 1'b1},
    {1'b0, 8'h40, 8'h40, 1'b0},
    {1'b1, 8'hFF, 8'hFF, 1'b0},
    {1'b1, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h5A, 8'h5A, 1'b0},
    {1'b1, 8'h81, 8'h81, 1'b0},
    {1'b0, 8'h0C, 8'h04, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] selCode(input int s);
    logic [7:0] r = 8'h00;
    if (s >= 1 && s <= 8) r[s-1] = 1'b1;
    return r;
  endfunction

  initial begin
    #(5.0 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; txMode = 1'b0; txSel = 4'd0; txData = 8'h00;
    useLoop = 1'b0; drvMode = 1'b1; drvBus = 8'hFF;
    @(posedge clk); @(posedge clk); #1;
    check("R8 reset value", rxData, 8'h00);

    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R8 capture after reset", rxData, 8'hFF);
    @(negedge clk); drvBus = 8'h3C; #1;
    check("R8 hold between edges", rxData, 8'hFF);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R8 reset clears", rxData, 8'h00);
    @(negedge clk); rst = 1'b0;

    // table-driven receiver vectors
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      drvMode = VEC[i][17];
      drvBus  = VEC[i][16:9];
      #1;
      check(VEC[i][17] ? "R7 flag data" : "R7 flag opcode", {7'b0, rxMultiHot}, {7'b0, VEC[i][0]});
      @(posedge clk); #1;
      if (VEC[i][17])              check("R6 passthrough", rxData, VEC[i][8:1]);
      else if (VEC[i][16:9] == 0)  check("R5 empty opcode", rxData, VEC[i][8:1]);
      else                         check("R4 lowest bit", rxData, VEC[i][8:1]);
    end

    // transmitter mapping, including illegal selectors
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      txMode = 1'b0; txSel = 4'(s); #1;
      check(s <= 8 ? "R1 selector code" : "R2 illegal selector", busData, selCode(s));
    end
    @(negedge clk); txMode = 1'b1; txData = 8'hC3; #1;
    check("R3 raw forward", busData, 8'hC3);
    check("R3 mode line", {7'b0, busMode}, 8'h01);

    // round trips
    useLoop = 1'b1;
    for (int s = 0; s <= 8; s++) begin
      @(negedge clk);
      txMode = 1'b0; txSel = 4'(s);
      @(posedge clk); #1;
      check("R9 opcode round trip", rxData, selCode(s));
    end
    for (int n = 0; n < 20; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      @(negedge clk);
      txMode = 1'b1; txData = b;
      @(posedge clk); #1;
      check("R9 data round trip", rxData, b);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule